// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recently used page-table entries so that a virtual page number can be turned into a physical frame number without walking the page table. Each entry is tagged by virtual page number and by address-space identifier, so translations from different address spaces can sit in the table together. Every lookup compares its tag against all entries in parallel. One cycle later the block gives a hit with the frame number and protection bits, a permission fault, or a miss. Pages are the same size on both sides, so the page offset never enters the block.

The logic that handles a miss sits outside the block. It either walks the page table in hardware or runs a software handler, and then writes the new entry through the refill port. When there is no free slot, the entry to replace is picked by a free-running shift register. Entries can be removed one address space at a time or all at once.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid: `rsp_valid` is low, and the first lookup reports a miss.
- R2: A lookup on cycle N whose VPN and ASID match a valid entry, and whose requested access is allowed, produces `rsp_valid`, `rsp_hit`, that entry's frame number on `rsp_pfn` and its permission bits on `rsp_perm` on cycle N+1.
- R3: An entry matches only when its ASID equals the lookup ASID. The same VPN under another ASID misses.
- R4: Permission bits are bit 0 = read, bit 1 = write, bit 2 = execute. If the tag matches but a bit set in `lk_need` is clear in the entry, the response is `rsp_fault`, with `rsp_hit` and `rsp_miss` low.
- R5: If no valid entry matches, the response is `rsp_miss` with `rsp_pfn` and `rsp_perm` zero.
- R6: While any entry is invalid, a refill of a new tag fills an invalid slot and no valid entry is lost.
- R7: When all entries are valid, a refill of a new tag replaces exactly one entry, chosen by a free-running pseudo-random register.
- R8: A refill whose VPN and ASID already match an entry rewrites that entry in place and evicts nothing.
- R9: A per-ASID flush (`fl_asid_valid`, `fl_asid`) invalidates every entry with that ASID and leaves all others.
- R10: `fl_all` invalidates every entry.
- R11: A lookup in the same cycle as a refill is reported as a miss, and the refilled entry hits on later lookups.
- R12: When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` is high. All four are low in the cycle after a cycle with no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_need | input | PERM_W | Access kinds required (read, write, execute) |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_asid | input | ASID_W | Refill address-space identifier |
| rf_pfn | input | PFN_W | Refill physical frame number |
| rf_perm | input | PERM_W | Refill permission bits |
| fl_asid_valid | input | 1 | Flush the entries of one ASID |
| fl_asid | input | ASID_W | ASID to flush |
| fl_all | input | 1 | Flush every entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No valid match, or the lookup collided with a refill |
| rsp_fault | output | 1 | Match found but the access is not permitted |
| rsp_pfn | output | PFN_W | Frame number on a hit, else zero |
| rsp_perm | output | PERM_W | Permission bits on a hit, else zero |

## Verification
A lookup's response is registered, so it is due exactly one rising edge after the request. The bench drives each request on a falling edge and samples the response on the next falling edge, one full cycle later. Refills and flushes take effect for lookups issued in the following cycle, so every probe starts after the write cycle has ended. The random victim cannot be predicted, so after each full-table refill the bench probes all previously held tags, requires exactly one of them to be gone, and drops that one from its model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Bit positions inside a permission field
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    // Outcome of a lookup
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_HIT   = 2'd1,
        KIND_MISS  = 2'd2,
        KIND_FAULT = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             match
);
    // One comparator per entry, all evaluated at once
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (vpn[g] == key_vpn) && (asid[g] == key_asid);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int LFSR_W  = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;
    logic [IDX_W-1:0]  free_idx;
    logic              any_free;

    always_comb begin
        // Galois shift, advancing every cycle
        lfsr_d   = lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_TAPS) : (lfsr_q >> 1);
        any_free = ~&valid;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
        victim = any_free ? free_idx : lfsr_q[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= LFSR_W'(1);
        else        lfsr_q <= lfsr_d;
    end

    assert_victim_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> !valid[victim]);
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PERM_W  = 3,
    parameter int LFSR_W  = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PERM_W-1:0] lk_need,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [PERM_W-1:0] rf_perm,
    input  logic              fl_asid_valid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [PERM_W-1:0] rsp_perm
);
    import tlb_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
        rsp_kind_e                      kind;
        logic [PFN_W-1:0]               rsp_pfn;
        logic [PERM_W-1:0]              rsp_perm;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] lk_match, rf_match;
    logic [IDX_W-1:0]   victim, rf_slot;
    logic [PFN_W-1:0]   sel_pfn;
    logic [PERM_W-1:0]  sel_perm;
    logic               lk_any, allowed;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .valid(s_q.valid), .vpn(s_q.vpn), .asid(s_q.asid),
        .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
        .valid(s_q.valid), .vpn(s_q.vpn), .asid(s_q.asid),
        .key_vpn(rf_vpn), .key_asid(rf_asid), .match(rf_match)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(s_q.valid), .victim(victim)
    );

    always_comb begin
        s_d      = s_q;
        sel_pfn  = '0;
        sel_perm = '0;
        rf_slot  = victim;
        // At most one entry matches, so OR-ing selects it
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_pfn  = sel_pfn | s_q.pfn[i];
                sel_perm = sel_perm | s_q.perm[i];
            end
            if (rf_match[i]) rf_slot = IDX_W'(i);
        end
        lk_any  = |lk_match;
        allowed = ((sel_perm & lk_need) == lk_need);

        // Response, registered for the next cycle
        if (!lk_valid)                 s_d.kind = KIND_NONE;
        else if (rf_valid || !lk_any)  s_d.kind = KIND_MISS;
        else if (allowed)              s_d.kind = KIND_HIT;
        else                           s_d.kind = KIND_FAULT;
        s_d.rsp_pfn  = (s_d.kind == KIND_HIT) ? sel_pfn  : '0;
        s_d.rsp_perm = (s_d.kind == KIND_HIT) ? sel_perm : '0;

        // Invalidation, then refill on top of it
        for (int i = 0; i < ENTRIES; i++) begin
            if (fl_all || (fl_asid_valid && (s_q.asid[i] == fl_asid))) s_d.valid[i] = 1'b0;
        end
        if (rf_valid) begin
            s_d.valid[rf_slot] = 1'b1;
            s_d.vpn[rf_slot]   = rf_vpn;
            s_d.asid[rf_slot]  = rf_asid;
            s_d.pfn[rf_slot]   = rf_pfn;
            s_d.perm[rf_slot]  = rf_perm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = (s_q.kind != KIND_NONE);
    assign rsp_hit   = (s_q.kind == KIND_HIT);
    assign rsp_miss  = (s_q.kind == KIND_MISS);
    assign rsp_fault = (s_q.kind == KIND_FAULT);
    assign rsp_pfn   = s_q.rsp_pfn;
    assign rsp_perm  = s_q.rsp_perm;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_fault));
    assert_one_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    assert_collide_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && rf_valid) |=> rsp_miss);
    assert_flush_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_all && !rf_valid) |=> (s_q.valid == '0));
    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_pfn == '0 && rsp_perm == '0));
endmodule

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic [2:0]  lk_need = '0;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic [19:0] rf_pfn = '0;
    logic [2:0]  rf_perm = '0;
    logic        fl_asid_valid = 1'b0;
    logic [7:0]  fl_asid = '0;
    logic        fl_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [19:0] rsp_pfn;
    logic [2:0]  rsp_perm;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    tlb_fa dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_need(lk_need),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
        .fl_asid_valid(fl_asid_valid), .fl_asid(fl_asid), .fl_all(fl_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm)
    );

    // Behavioural model: an unordered list of live translations
    typedef struct { int vpn; int asid; int pfn; int perm; } ment_t;
    ment_t mq[$];

    function automatic int mfind(int vpn, int asid);
        foreach (mq[k]) if (mq[k].vpn == vpn && mq[k].asid == asid) return k;
        return -1;
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Lookup, sampled one cycle later, compared with the model
    task automatic look(int vpn, int asid, int need, string rq);
        int  k;
        int  ekind, epfn, eperm;
        k = mfind(vpn, asid);
        if (k < 0) begin ekind = 2; epfn = 0; eperm = 0; end
        else if ((mq[k].perm & need) == need) begin ekind = 1; epfn = mq[k].pfn; eperm = mq[k].perm; end
        else begin ekind = 3; epfn = 0; eperm = 0; end
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn[19:0]; lk_asid = asid[7:0]; lk_need = need[2:0];
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid && (rsp_hit == (ekind == 1)) && (rsp_miss == (ekind == 2)) && (rsp_fault == (ekind == 3)),
            rq, "kind {v,h,m,f}", {rsp_valid, rsp_hit, rsp_miss, rsp_fault},
            {1'b1, ekind == 1, ekind == 2, ekind == 3});
        chk(rsp_pfn == epfn[19:0] && rsp_perm == eperm[2:0], rq, "pfn/perm",
            {rsp_pfn, rsp_perm}, {epfn[19:0], eperm[2:0]});
        chk($countones({rsp_hit, rsp_miss, rsp_fault}) == 1, "R12", "one kind",
            {rsp_hit, rsp_miss, rsp_fault}, 0);
    endtask

    task automatic probe(int vpn, int asid, output bit present);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn[19:0]; lk_asid = asid[7:0]; lk_need = 3'b000;
        @(negedge clk);
        lk_valid = 1'b0;
        present = rsp_hit;
    endtask

    task automatic drive_refill(int vpn, int asid, int pfn, int perm);
        rf_valid = 1'b1; rf_vpn = vpn[19:0]; rf_asid = asid[7:0];
        rf_pfn = pfn[19:0]; rf_perm = perm[2:0];
    endtask

    task automatic refill(int vpn, int asid, int pfn, int perm);
        int  k;
        ment_t e;
        e.vpn = vpn; e.asid = asid; e.pfn = pfn; e.perm = perm;
        @(negedge clk);
        drive_refill(vpn, asid, pfn, perm);
        @(negedge clk);
        rf_valid = 1'b0;
        k = mfind(vpn, asid);
        if (k >= 0) mq[k] = e;
        else if (mq.size() < N) mq.push_back(e);
        else begin
            // R7: exactly one earlier tag must be gone
            int gone = 0;
            for (int j = mq.size() - 1; j >= 0; j--) begin
                bit p;
                probe(mq[j].vpn, mq[j].asid, p);
                if (!p) begin gone++; mq.delete(j); end
            end
            chk(gone == 1, "R7", "evicted count", gone, 1);
            mq.push_back(e);
        end
    endtask

    task automatic flush(bit all, int asid);
        @(negedge clk);
        fl_all = all; fl_asid_valid = !all; fl_asid = asid[7:0];
        @(negedge clk);
        fl_all = 1'b0; fl_asid_valid = 1'b0;
        for (int j = mq.size() - 1; j >= 0; j--) begin
            if (all || mq[j].asid == asid) mq.delete(j);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault, "R1", "outputs in reset",
            {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R12", "idle response", rsp_valid, 0);
        look(5, 9, 1, "R1");
        look(77, 3, 0, "R5");

        // R6: fill every slot; nothing may be lost
        for (int i = 0; i < N; i++) begin
            int pm;
            case (i % 4)
                0: pm = 1; 1: pm = 3; 2: pm = 5; default: pm = 7;
            endcase
            refill(i * 3 + 1, (i % 2) ? 5 : 9, 100 + i, pm);
        end
        for (int i = 0; i < N; i++) look(i * 3 + 1, (i % 2) ? 5 : 9, 1, "R6");

        // R2 with several access kinds
        look(4, 5, 3, "R2");
        look(10, 5, 7, "R2");
        // R3: same VPN, wrong ASID
        look(1, 5, 0, "R3");
        look(4, 9, 0, "R3");
        // R4: write and execute requested on entries lacking them
        look(1, 9, 2, "R4");
        look(4, 5, 4, "R4");
        look(7, 9, 2, "R4");

        // R8: rewrite an existing tag in place
        refill(4, 5, 555, 7);
        for (int i = 0; i < N; i++) look(i * 3 + 1, (i % 2) ? 5 : 9, 0, "R8");
        look(4, 5, 7, "R8");

        // R7: new tags into a full table
        for (int r = 0; r < 3; r++) begin
            refill(900 + r, 9, 700 + r, 7);
            look(900 + r, 9, 1, "R7");
        end

        // R9: flush one address space
        flush(1'b0, 5);
        foreach (mq[k]) look(mq[k].vpn, mq[k].asid, 0, "R9");
        look(4, 5, 0, "R9");

        // R11: lookup colliding with a refill
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'd1; lk_asid = 8'd9; lk_need = 3'b000;
        drive_refill(333, 7, 444, 3);
        @(negedge clk);
        lk_valid = 1'b0; rf_valid = 1'b0;
        chk(rsp_valid && rsp_miss && !rsp_hit, "R11", "collision miss",
            {rsp_valid, rsp_miss, rsp_hit}, 3'b110);
        begin
            ment_t e;
            e.vpn = 333; e.asid = 7; e.pfn = 444; e.perm = 3;
            mq.push_back(e);
        end
        look(333, 7, 3, "R11");
        look(1, 9, 0, "R11");

        // R10: flush everything
        flush(1'b1, 0);
        look(333, 7, 0, "R10");
        look(1, 9, 0, "R10");
        look(900, 9, 0, "R10");
        @(negedge clk);
        chk(!rsp_valid, "R12", "idle after lookup", rsp_valid, 0);

        summary();
    end
endmodule